// File: doc/BRIEF.md
# Edge-Triggered Interrupt GPIO Port

This block is an 8-bit general-purpose I/O port whose input bits can raise interrupt requests on a chosen edge. Each bit has its own direction control and its own edge-polarity control. A byte-wide register port gives access to the port data, the direction setting and the edge setting. Eight pin inputs, eight pin outputs and eight output enables face the outside world.

External inputs pass through a two-stage synchroniser. The block keeps the last synchronised level of every bit. An edge is detected when that stored level is not the bit's selected polarity and the fresh level is. Each detected edge turns into a one-cycle request pulse on one of sixteen interrupt levels, but only when the enable input for that level is high. The eight bits land on fixed, non-contiguous levels: bits 0 to 3 go to levels 0 to 3, bits 4 and 5 go to levels 6 and 7, and bits 6 and 7 go to levels 14 and 15. Levels 4, 5 and 8 to 13 belong to other sources and stay low here. Prioritisation, vectoring and acknowledge are left to the interrupt controller that receives the pulses.

Top module: `gpio_edge_irq`

## Requirements
- R1: After a synchronous reset, the direction register, the edge register, the output latch, `pin_out`, `pin_oe` and `irq_pulse` are all zero, and reads of the direction and edge registers return 0.
- R2: A read at address 0 returns, in the next cycle on `reg_rdata`, the synchronised pin level for bits whose direction bit is 0 and the output latch for bits whose direction bit is 1.
- R3: A write at address 0 stores `reg_wdata` ANDed with the direction register into the output latch, which drives `pin_out` from the following cycle. `pin_oe` equals the direction register. Without such a write, `pin_out` does not change.
- R4: Address 1 (direction) and address 2 (edge select) read back the last value written, one cycle after the address is presented. Address 3 reads as 0.
- R5: An edge on bit b is detected when the previously sampled level differs from edge bit b and the new sampled level equals it. Edge bit 1 selects rising edges and 0 selects falling edges. The opposite transition raises nothing, and changing the edge register while the pins are steady raises nothing.
- R6: A detected edge produces a pulse only if `int_en` at the bit's level is 1.
- R7: Bit b maps to level b for b = 0..3, to level b+2 for b = 4..5, and to level b+8 for b = 6..7. Levels 4, 5 and 8..13 never pulse.
- R8: A pin change that is stable from just after a clock edge shows on `irq_pulse` after the third following rising edge. It stays high for exactly one cycle per detected edge.
- R9: The stored previous level resets to 0 and then follows the synchronised pin every cycle, whether or not an event is raised.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | 2 | Register select: 0 port data, 1 direction, 2 edge select |
| reg_wr | input | 1 | Write strobe for the selected register |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Registered read data for the address of the previous cycle |
| pin_in | input | 8 | Asynchronous external pin levels |
| pin_out | output | 8 | Output latch value driven to the pins |
| pin_oe | output | 8 | Per-bit output enable (direction register) |
| int_en | input | 16 | Per-level interrupt enable from the interrupt controller |
| irq_pulse | output | 16 | One-cycle request pulses per interrupt level |

## Verification
An interrupt pulse is due at the third rising edge after a pin change. The bench drives pins just after a falling edge and samples `irq_pulse` at the falling edges after the second, third and fourth rising edges. It expects zero, then the computed level mask, then zero again. Register reads are due one edge after the address is presented, and output-latch writes show on `pin_out` one edge after the strobe. Reads of the port data wait at least three cycles after a pin change, so the synchroniser has settled before the result is compared.

// File: rtl/gpio_edge_pkg.sv
package gpio_edge_pkg;

  typedef enum logic [1:0] {
    SEL_PORT = 2'd0,
    SEL_DIR  = 2'd1,
    SEL_EDGE = 2'd2,
    SEL_NONE = 2'd3
  } reg_sel_e;

  // Fixed placement of port bits among the interrupt levels.
  function automatic int unsigned pin_level(input int unsigned b);
    if (b < 4)      return b;
    else if (b < 6) return b + 2;
    else            return b + 8;
  endfunction

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int WIDTH  = 8,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  logic [STAGES-1:0][WIDTH-1:0] stage_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      stage_q <= '0;
    end else begin
      stage_q[0] <= d;
      for (int s = 1; s < STAGES; s++) begin
        stage_q[s] <= stage_q[s-1];
      end
    end
  end

  assign q = stage_q[STAGES-1];

endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
  import gpio_edge_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [1:0]       addr,
  input  logic             wr,
  input  logic [WIDTH-1:0] wdata,
  input  logic [WIDTH-1:0] pin_sync,
  output logic [WIDTH-1:0] dir_q,
  output logic [WIDTH-1:0] edge_q,
  output logic [WIDTH-1:0] out_q,
  output logic [WIDTH-1:0] rdata_q
);

  reg_sel_e sel;
  assign sel = reg_sel_e'(addr);

  always_ff @(posedge clk) begin
    if (rst) begin
      dir_q  <= '0;
      edge_q <= '0;
      out_q  <= '0;
    end else if (wr) begin
      case (sel)
        SEL_PORT: out_q  <= wdata & dir_q;
        SEL_DIR:  dir_q  <= wdata;
        SEL_EDGE: edge_q <= wdata;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q <= '0;
    end else begin
      case (sel)
        SEL_PORT: rdata_q <= (pin_sync & ~dir_q) | (out_q & dir_q);
        SEL_DIR:  rdata_q <= dir_q;
        SEL_EDGE: rdata_q <= edge_q;
        default:  rdata_q <= '0;
      endcase
    end
  end

  // R3
  port_write_chk: assert property (@(posedge clk) disable iff (rst)
    (wr && sel == SEL_PORT) |=> out_q == $past(wdata & dir_q));

  // R3
  port_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !(wr && sel == SEL_PORT) |=> $stable(out_q));

  // R4
  dir_readback_chk: assert property (@(posedge clk) disable iff (rst)
    (sel == SEL_DIR) |=> rdata_q == $past(dir_q));

endmodule

// File: rtl/gpio_edge_det.sv
module gpio_edge_det
  import gpio_edge_pkg::*;
#(
  parameter int WIDTH  = 8,
  parameter int LEVELS = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [WIDTH-1:0]  cur,
  input  logic [WIDTH-1:0]  edge_sel,
  input  logic [LEVELS-1:0] int_en,
  output logic [LEVELS-1:0] irq_q
);

  logic [WIDTH-1:0]  prev_q;
  logic [WIDTH-1:0]  hit;
  logic [LEVELS-1:0] req_d;

  // Event: old level was off the selected polarity, new level is on it.
  assign hit = (prev_q ^ edge_sel) & ~(cur ^ edge_sel);

  always_comb begin
    req_d = '0;
    for (int b = 0; b < WIDTH; b++) begin
      req_d[pin_level(b)] = hit[b] & int_en[pin_level(b)];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q <= '0;
      irq_q  <= '0;
    end else begin
      prev_q <= cur;
      irq_q  <= req_d;
    end
  end

  for (genvar b = 0; b < WIDTH; b++) begin : g_chk
    localparam int unsigned LVL = pin_level(b);

    // R8
    pulse_single_chk: assert property (@(posedge clk) disable iff (rst)
      (irq_q[LVL] && $stable(edge_sel[b])) |=> !irq_q[LVL]);

    // R6
    enable_gate_chk: assert property (@(posedge clk) disable iff (rst)
      irq_q[LVL] |-> $past(int_en[LVL]));

    // R5
    edge_rule_chk: assert property (@(posedge clk) disable iff (rst)
      irq_q[LVL] |-> ($past(cur[b]) == $past(edge_sel[b])));
  end

endmodule

// File: rtl/gpio_edge_irq.sv
module gpio_edge_irq
  import gpio_edge_pkg::*;
#(
  parameter int WIDTH       = 8,
  parameter int LEVELS      = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        reg_addr,
  input  logic              reg_wr,
  input  logic [WIDTH-1:0]  reg_wdata,
  output logic [WIDTH-1:0]  reg_rdata,
  input  logic [WIDTH-1:0]  pin_in,
  output logic [WIDTH-1:0]  pin_out,
  output logic [WIDTH-1:0]  pin_oe,
  input  logic [LEVELS-1:0] int_en,
  output logic [LEVELS-1:0] irq_pulse
);

  logic [WIDTH-1:0] pin_sync;
  logic [WIDTH-1:0] dir_q;
  logic [WIDTH-1:0] edge_q;
  logic [WIDTH-1:0] out_q;

  gpio_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (pin_in),
    .q   (pin_sync)
  );

  gpio_regs #(.WIDTH(WIDTH)) u_regs (
    .clk      (clk),
    .rst      (rst),
    .addr     (reg_addr),
    .wr       (reg_wr),
    .wdata    (reg_wdata),
    .pin_sync (pin_sync),
    .dir_q    (dir_q),
    .edge_q   (edge_q),
    .out_q    (out_q),
    .rdata_q  (reg_rdata)
  );

  gpio_edge_det #(.WIDTH(WIDTH), .LEVELS(LEVELS)) u_edge (
    .clk      (clk),
    .rst      (rst),
    .cur      (pin_sync),
    .edge_sel (edge_q),
    .int_en   (int_en),
    .irq_q    (irq_pulse)
  );

  assign pin_out = out_q;
  assign pin_oe  = dir_q;

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    $past(rst) |-> (irq_pulse == '0 && pin_oe == '0 && pin_out == '0));

endmodule

// File: tb/test_gpio_edge_irq.sv
module test_gpio_edge_irq;

  logic        clk = 1'b0;
  logic        rst;
  logic [1:0]  reg_addr;
  logic        reg_wr;
  logic [7:0]  reg_wdata;
  logic [7:0]  reg_rdata;
  logic [7:0]  pin_in;
  logic [7:0]  pin_out;
  logic [7:0]  pin_oe;
  logic [15:0] int_en;
  logic [15:0] irq_pulse;

  int n_chk  = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  gpio_edge_irq i_gpio_edge_irq (
    .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe(pin_oe), .int_en(int_en), .irq_pulse(irq_pulse)
  );

  // Stimulus: {edge select, pins before, pins after, level enables}
  localparam int NV = 8;
  localparam logic [39:0] VEC [NV] = '{
    {8'hFF, 8'h00, 8'hFF, 16'hFFFF},
    {8'h00, 8'hFF, 8'h00, 16'hFFFF},
    {8'hFF, 8'hFF, 8'h00, 16'hFFFF},
    {8'h0F, 8'hF0, 8'h0F, 16'hFFFF},
    {8'hFF, 8'h00, 8'hFF, 16'h00FF},
    {8'h00, 8'hFF, 8'h00, 16'h4041},
    {8'h55, 8'h00, 8'hFF, 16'hFFFF},
    {8'h55, 8'hFF, 8'h00, 16'hFFFF}
  };

  function automatic int tb_level(input int b);
    return (b < 4) ? b : (b < 6) ? b + 2 : b + 8;
  endfunction

  function automatic logic [15:0] expect_irq(input logic [7:0] sel, pre, post,
                                             input logic [15:0] en);
    logic [15:0] m = '0;
    for (int b = 0; b < 8; b++) begin
      if (pre[b] != sel[b] && post[b] == sel[b] && en[tb_level(b)])
        m[tb_level(b)] = 1'b1;
    end
    return m;
  endfunction

  task automatic check(input string req, input logic [15:0] act, exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic reg_write(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic reg_read(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    reg_addr = a;
    @(negedge clk);
    d = reg_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset(input logic [7:0] pins);
    @(negedge clk);
    rst = 1'b1; pin_in = pins;
    idle(3);
    rst = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [7:0]  rd;
    logic [15:0] exp;
    logic [15:0] seen;
    rst = 1'b1; reg_addr = '0; reg_wr = 1'b0; reg_wdata = '0;
    pin_in = '0; int_en = 16'hFFFF;
    do_reset(8'h00);

    // R1 reset state
    check("R1 pin_out", {8'h0, pin_out}, 16'h0);
    check("R1 pin_oe", {8'h0, pin_oe}, 16'h0);
    check("R1 irq", irq_pulse, 16'h0);
    reg_read(2'd1, rd); check("R1 dir read", {8'h0, rd}, 16'h0);
    reg_read(2'd2, rd); check("R1 edge read", {8'h0, rd}, 16'h0);

    // Table walk: R5 R6 R7 R8
    for (int v = 0; v < NV; v++) begin
      logic [7:0]  sel  = VEC[v][39:32];
      logic [7:0]  pre  = VEC[v][31:24];
      logic [7:0]  post = VEC[v][23:16];
      logic [15:0] en   = VEC[v][15:0];
      reg_write(2'd2, sel);
      @(negedge clk);
      pin_in = pre; int_en = en;
      idle(6);
      pin_in = post;
      exp = expect_irq(sel, pre, post, en);
      @(posedge clk); @(posedge clk); @(negedge clk);
      check($sformatf("R8 early v%0d", v), irq_pulse, 16'h0);
      @(posedge clk); @(negedge clk);
      check($sformatf("R5/R6/R7 pulse v%0d", v), irq_pulse, exp);
      @(posedge clk); @(negedge clk);
      check($sformatf("R8 one-cycle v%0d", v), irq_pulse, 16'h0);
    end

    // R7: unmapped levels stay low with all enables set and all bits toggling
    int_en = 16'hFFFF;
    reg_write(2'd2, 8'hFF);
    @(negedge clk); pin_in = 8'h00; idle(6);
    pin_in = 8'hFF;
    seen = '0;
    repeat (6) begin @(negedge clk); seen |= irq_pulse; end
    check("R7 mapped set", seen, 16'hC0CF);

    // R5: changing edge select with steady pins raises nothing
    seen = '0;
    @(negedge clk);
    reg_addr = 2'd2; reg_wdata = 8'h00; reg_wr = 1'b1;
    @(negedge clk); reg_wr = 1'b0;
    repeat (6) begin @(negedge clk); seen |= irq_pulse; end
    check("R5 select change", seen, 16'h0);

    // R2 R3 R4 port data and direction
    reg_write(2'd1, 8'h0F);
    check("R3 pin_oe", {8'h0, pin_oe}, 16'h000F);
    reg_write(2'd0, 8'hFF);
    check("R3 pin_out masked", {8'h0, pin_out}, 16'h000F);
    @(negedge clk); pin_in = 8'hA0; idle(4);
    reg_read(2'd0, rd); check("R2 port read", {8'h0, rd}, 16'h00AF);
    reg_read(2'd1, rd); check("R4 dir read", {8'h0, rd}, 16'h000F);
    reg_write(2'd2, 8'h3C);
    reg_read(2'd2, rd); check("R4 edge read", {8'h0, rd}, 16'h003C);
    reg_read(2'd3, rd); check("R4 addr3 read", {8'h0, rd}, 16'h0);
    reg_write(2'd1, 8'h00);
    check("R3 pin_out held", {8'h0, pin_out}, 16'h000F);
    reg_write(2'd0, 8'hFF);
    check("R3 pin_out zero dir", {8'h0, pin_out}, 16'h0000);

    // R9: pins high through reset under falling select, then switch to rising
    int_en = 16'hFFFF;
    do_reset(8'hFF);
    seen = '0;
    repeat (8) begin @(negedge clk); seen |= irq_pulse; end
    check("R9 rise after reset ignored", seen, 16'h0);
    reg_write(2'd2, 8'hFF);
    seen = '0;
    repeat (6) begin @(negedge clk); seen |= irq_pulse; end
    check("R9 prev tracks pin", seen, 16'h0);
    @(negedge clk); pin_in = 8'h00; idle(6);
    pin_in = 8'h81;
    @(posedge clk); @(posedge clk); @(posedge clk); @(negedge clk);
    check("R9 later rise", irq_pulse, 16'h8001);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

endmodule